// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits beside an Ethernet receive path and decides, from the 48-bit destination address alone, whether the frame being received is kept. Address bytes enter one at a time, in the order they appear on the wire, and a first-byte marker starts each frame. After the sixth byte the block issues a single-cycle decision strobe together with the accept flag and the 6-bit hash it computed.

Multicast destinations are matched through a 64-entry bit table that software loads as two 32-bit words. The hash is not a CRC. Each address byte contributes an XOR of two shifted copies of itself, the shift pair cycles with a period of three bytes, and the running XOR is cut to six bits. Broadcast and promiscuous acceptance come from single bits of a control word. Unicast destinations are compared with a programmed station address. All configuration inputs are expected to stay stable while a frame is in flight.

Top module: `mhf_dest_filter`

## Requirements
- R1: The hash starts from zero at the first byte and XORs one term per byte. Bytes 0 and 3 add (b>>2)^(b<<4), bytes 1 and 4 add (b>>4)^(b<<2), and bytes 2 and 5 add (b>>6)^b. The low 6 bits of the result appear on `dec_hash` with the decision. For example, 01:00:5E:00:00:01 gives 14 and 01:00:5E:00:00:21 gives 46.
- R2: A multicast destination, meaning bit 0 of byte 0 is 1 and the address is not all ones, is accepted only when control bit 5 is set and the table bit selected by the hash is set. Hash values 0 to 31 select bit `hash` of `cfg_hash_lo`, and values 32 to 63 select bit `hash-32` of `cfg_hash_hi`.
- R3: With control bit 5 set and both table words at all ones, every multicast destination is accepted.
- R4: When control bit 21 is set, every frame is accepted whatever its address and whatever the other settings.
- R5: The all-ones destination is accepted only when control bit 13 is set (or bit 21 is set), whatever the hash table holds.
- R6: A destination with bit 0 of byte 0 clear is accepted only when all six bytes equal the station address. Station bytes 0 to 3 sit little-endian in `cfg_stn_w0` (byte 0 in bits 7:0), byte 4 is `cfg_stn_b4` and byte 5 is `cfg_stn_b5`.
- R7: `dec_valid` is high for exactly the one cycle after the clock edge that takes the sixth address byte. Idle cycles between bytes delay the decision but do not change it.
- R8: Bytes that arrive after the sixth byte, or after reset without a first-byte marker, are ignored. A first-byte marker always restarts the count, even in the middle of an address.
- R9: After reset `dec_valid` and `dec_accept` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 32 | Control word: bit 21 promiscuous, bit 13 broadcast, bit 5 multicast |
| cfg_hash_lo | input | 32 | Hash table entries 0 to 31 |
| cfg_hash_hi | input | 32 | Hash table entries 32 to 63 |
| cfg_stn_w0 | input | 32 | Station address bytes 0 to 3, little-endian |
| cfg_stn_b4 | input | 8 | Station address byte 4 |
| cfg_stn_b5 | input | 8 | Station address byte 5 |
| in_valid | input | 1 | An address byte is present this cycle |
| in_first | input | 1 | The present byte is byte 0 of a new destination |
| in_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame is accepted; meaningful while `dec_valid` is high |
| dec_hash | output | 6 | Hash of the destination; meaningful while `dec_valid` is high |

## Verification
Each result is due exactly one cycle after the clock edge that takes the sixth address byte: the hash and the class flags are folded combinationally with that byte, and only the decision register follows. The bench drives each byte just after a falling edge. It reads `dec_valid`, `dec_accept` and `dec_hash` at the falling edge that follows the sixth byte's rising edge, and it confirms one falling edge later that the strobe has dropped. In the tests that insert idle cycles or extra bytes, the strobe is also sampled at every intermediate falling edge, so an early or repeated strobe is caught.

// File: rtl/mhf_pkg.sv
// Package: shared sizes and the per-byte hash term of the destination filter.
// Assumes a 48-bit destination delivered as six bytes, byte 0 first.
package mhf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int HASH_W     = 6;
    localparam int WORD_W     = 32;
    localparam int IDX_W      = $clog2(ADDR_BYTES + 1);

    // Term folded into the hash for the byte at position pos.
    // The shift pair repeats every three bytes.
    function automatic logic [HASH_W-1:0] hash_term(input logic [IDX_W-1:0] pos,
                                                    input logic [7:0]       b);
        logic [7:0] t;
        case (pos)
            IDX_W'(0), IDX_W'(3): t = (b >> 2) ^ (b << 4);
            IDX_W'(1), IDX_W'(4): t = (b >> 4) ^ (b << 2);
            default:              t = (b >> 6) ^ b;
        endcase
        return t[HASH_W-1:0];
    endfunction

endpackage

// File: rtl/mhf_byte_tracker.sv
// Module: counts destination bytes within a frame.
// Assumes in_first marks byte 0; after the last byte, or after reset, it ignores
// bytes until the next in_first.
module mhf_byte_tracker #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    output logic [IDX_W-1:0] cur_idx,
    output logic             take,
    output logic             last
);

    localparam logic [IDX_W-1:0] IDLE_POS = IDX_W'(ADDR_BYTES);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(ADDR_BYTES - 1);

    logic [IDX_W-1:0] cnt_q;

    // Position of the byte on the input, and whether it is taken.
    always_comb begin
        cur_idx = in_first ? '0 : cnt_q;
        take    = in_valid && (in_first || (cnt_q != IDLE_POS));
        last    = take && (cur_idx == LAST_POS);
    end

    // Advance the position on each byte that is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= IDLE_POS;
        else if (take)
            cnt_q <= cur_idx + 1'b1;
    end

    // R8: once idle, only a first-byte marker leaves the idle state.
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == IDLE_POS && !(in_valid && in_first)) |=> (cnt_q == IDLE_POS));

endmodule

// File: rtl/mhf_hash_accum.sv
// Module: folds each destination byte into the 6-bit hash.
// Assumes cur_idx and take come from the byte tracker.
// hash_next includes the byte present this cycle.
module mhf_hash_accum
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic              take,
    input  logic [7:0]        in_byte,
    output logic [HASH_W-1:0] hash_next
);

    logic [HASH_W-1:0] hash_q;

    // Restart from zero on byte 0, otherwise fold into the running value.
    always_comb begin
        hash_next = ((cur_idx == '0) ? '0 : hash_q) ^ hash_term(cur_idx, in_byte);
    end

    // Hold the partial hash between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hash_q <= '0;
        else if (take)
            hash_q <= hash_next;
    end

endmodule

// File: rtl/mhf_addr_classify.sv
// Module: running address classification (group bit, all-ones, station match).
// Assumes the station address is stable during a frame; byte i is at stn_flat[8i+:8].
// The *_next outputs include the byte present this cycle.
module mhf_addr_classify #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        cur_idx,
    input  logic                    take,
    input  logic [7:0]              in_byte,
    input  logic [ADDR_BYTES*8-1:0] stn_flat,
    output logic                    grp_next,
    output logic                    ones_next,
    output logic                    stn_next
);

    logic grp_q, ones_q, stn_q;
    logic [7:0] ref_byte;
    logic first_pos;

    // Select the station byte for the current position.
    always_comb begin
        ref_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++)
            if (cur_idx == IDX_W'(i))
                ref_byte = stn_flat[8*i +: 8];
    end

    // Combine the current byte with the flags carried over from earlier bytes.
    always_comb begin
        first_pos = (cur_idx == '0);
        grp_next  = first_pos ? in_byte[0] : grp_q;
        ones_next = (first_pos || ones_q) && (in_byte == 8'hFF);
        stn_next  = (first_pos || stn_q) && (in_byte == ref_byte);
    end

    // Carry the flags to the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= 1'b0;
            ones_q <= 1'b0;
            stn_q  <= 1'b0;
        end else if (take) begin
            grp_q  <= grp_next;
            ones_q <= ones_next;
            stn_q  <= stn_next;
        end
    end

    // R6: once a byte has mismatched, a later byte of the same frame cannot restore the match.
    a_r6_match_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cur_idx != '0 && !stn_q) |=> !stn_q);

endmodule

// File: rtl/mhf_decide.sv
// Module: registered accept decision and hash output.
// Assumes the inputs are valid in the cycle that last is high.
// Priority: promiscuous, then broadcast, then multicast hash, then station match.
module mhf_decide
    import mhf_pkg::*;
#(
    parameter int PROMISC_BIT = 21,
    parameter int BCAST_BIT   = 13,
    parameter int MCAST_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last,
    input  logic [HASH_W-1:0] hash_next,
    input  logic              grp_next,
    input  logic              ones_next,
    input  logic              stn_next,
    input  logic [WORD_W-1:0] cfg_ctrl,
    input  logic [WORD_W-1:0] cfg_hash_lo,
    input  logic [WORD_W-1:0] cfg_hash_hi,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [HASH_W-1:0] dec_hash
);

    localparam int TABLE_BITS = 2 * WORD_W;

    logic [TABLE_BITS-1:0] table_bits;
    logic en_promisc, en_bcast, en_mcast, accept_now;

    // Work out the decision for the address completing this cycle.
    always_comb begin
        table_bits = {cfg_hash_hi, cfg_hash_lo};
        en_promisc = cfg_ctrl[PROMISC_BIT];
        en_bcast   = cfg_ctrl[BCAST_BIT];
        en_mcast   = cfg_ctrl[MCAST_BIT];
        if (en_promisc)
            accept_now = 1'b1;
        else if (ones_next)
            accept_now = en_bcast;
        else if (grp_next)
            accept_now = en_mcast && table_bits[hash_next];
        else
            accept_now = stn_next;
    end

    // Register the strobe, the flag and the hash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_hash   <= '0;
        end else begin
            dec_valid <= last;
            if (last) begin
                dec_accept <= accept_now;
                dec_hash   <= hash_next;
            end
        end
    end

    // R7: the strobe never lasts more than one cycle.
    a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R4: promiscuous mode always accepts.
    a_r4_promisc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (last && cfg_ctrl[PROMISC_BIT]) |=> dec_accept);

    // R5: broadcast is rejected without its enable (and without promiscuous mode).
    a_r5_bcast_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (last && ones_next && !cfg_ctrl[PROMISC_BIT] && !cfg_ctrl[BCAST_BIT]) |=> !dec_accept);

endmodule

// File: rtl/mhf_dest_filter.sv
// Module: top of the destination address hash filter.
// Assumes the configuration is stable while a destination is being received.
// The decision appears one cycle after the sixth address byte.
module mhf_dest_filter
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_ctrl,
    input  logic [WORD_W-1:0] cfg_hash_lo,
    input  logic [WORD_W-1:0] cfg_hash_hi,
    input  logic [WORD_W-1:0] cfg_stn_w0,
    input  logic [7:0]        cfg_stn_b4,
    input  logic [7:0]        cfg_stn_b5,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [7:0]        in_byte,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [HASH_W-1:0] dec_hash
);

    logic [IDX_W-1:0]        cur_idx;
    logic                    take, last;
    logic [HASH_W-1:0]       hash_next;
    logic                    grp_next, ones_next, stn_next;
    logic [ADDR_BYTES*8-1:0] stn_flat;

    // Gather the station address with byte 0 in the low bits.
    always_comb begin
        stn_flat = {cfg_stn_b5, cfg_stn_b4, cfg_stn_w0};
    end

    mhf_byte_tracker #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .cur_idx(cur_idx), .take(take), .last(last)
    );

    mhf_hash_accum u_hash (
        .clk(clk), .rst_n(rst_n), .cur_idx(cur_idx), .take(take),
        .in_byte(in_byte), .hash_next(hash_next)
    );

    mhf_addr_classify #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_class (
        .clk(clk), .rst_n(rst_n), .cur_idx(cur_idx), .take(take),
        .in_byte(in_byte), .stn_flat(stn_flat),
        .grp_next(grp_next), .ones_next(ones_next), .stn_next(stn_next)
    );

    mhf_decide u_dec (
        .clk(clk), .rst_n(rst_n), .last(last), .hash_next(hash_next),
        .grp_next(grp_next), .ones_next(ones_next), .stn_next(stn_next),
        .cfg_ctrl(cfg_ctrl), .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_hash(dec_hash)
    );

    // R7: the sixth byte taken by the tracker produces a strobe from the decision stage.
    a_r7_strobe_due: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> dec_valid);

endmodule

// File: tb/sim_mhf_dest_filter.sv
// Bench: a vector table walked by one loop, then directed tests for reset,
// timing and byte-sequence corner cases.
module sim_mhf_dest_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_ctrl = '0, cfg_hash_lo = '0, cfg_hash_hi = '0;
    logic [31:0] cfg_stn_w0 = 32'h3322_1102;
    logic [7:0]  cfg_stn_b4 = 8'h44, cfg_stn_b5 = 8'h55;
    logic        in_valid = 1'b0, in_first = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        dec_valid, dec_accept;
    logic [5:0]  dec_hash;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;

    always #10 clk = ~clk;

    mhf_dest_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl),
        .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
        .cfg_stn_w0(cfg_stn_w0), .cfg_stn_b4(cfg_stn_b4), .cfg_stn_b5(cfg_stn_b5),
        .in_valid(in_valid), .in_first(in_first), .in_byte(in_byte),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_hash(dec_hash)
    );

    // Table entry: address (byte 0 in the top bits), enables {promisc, bcast, mcast},
    // table choice: 0 empty, 1 all ones, 2 only the address's own hash bit, 3 only its neighbour bit.
    typedef struct packed {
        logic [47:0] addr;
        logic [2:0]  en;
        logic [1:0]  tsel;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{48'h01_00_5E_00_00_01, 3'b001, 2'd2},
        '{48'h01_00_5E_00_00_21, 3'b001, 2'd2},
        '{48'h01_00_5E_00_00_21, 3'b001, 2'd3},
        '{48'h01_00_5E_00_00_01, 3'b000, 2'd1},
        '{48'h33_33_00_00_00_01, 3'b001, 2'd1},
        '{48'hFF_FF_FF_FF_FF_FF, 3'b010, 2'd0},
        '{48'hFF_FF_FF_FF_FF_FF, 3'b001, 2'd1},
        '{48'h02_11_22_33_44_55, 3'b000, 2'd0},
        '{48'h02_11_22_33_44_56, 3'b000, 2'd0},
        '{48'h04_11_22_33_44_55, 3'b000, 2'd0},
        '{48'h0A_0B_0C_0D_0E_0F, 3'b100, 2'd0},
        '{48'hFF_FF_FF_FF_FF_FF, 3'b100, 2'd0}
    };

    // Hash of a destination, computed from the per-byte terms of R1.
    function automatic logic [5:0] model_hash(input logic [47:0] a);
        logic [7:0] h, b;
        h = '0;
        for (int i = 0; i < 6; i++) begin
            b = a[47-8*i -: 8];
            if (i % 3 == 0)      h = h ^ (b >> 2) ^ (b << 4);
            else if (i % 3 == 1) h = h ^ (b >> 4) ^ (b << 2);
            else                 h = h ^ (b >> 6) ^ b;
        end
        return h[5:0];
    endfunction

    // Expected accept flag following R2 to R6.
    function automatic logic model_accept(input logic [47:0] a, input logic [2:0] en,
                                          input logic [63:0] tbl);
        if (en[2])                   return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return en[1];
        if (a[40])                   return en[0] && tbl[model_hash(a)];
        return a == STATION;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_byte(input logic [7:0] b, input logic first);
        @(negedge clk);
        in_valid = 1'b1;
        in_first = first;
        in_byte  = b;
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    // Send a destination; on return the sixth byte has been taken one rising edge ago.
    task automatic send_addr(input logic [47:0] a);
        for (int i = 0; i < 6; i++)
            drive_byte(a[47-8*i -: 8], i == 0);
        go_idle();
    endtask

    task automatic set_cfg(input logic [2:0] en, input logic [63:0] tbl);
        cfg_ctrl    = '0;
        cfg_ctrl[21] = en[2];
        cfg_ctrl[13] = en[1];
        cfg_ctrl[5]  = en[0];
        cfg_hash_lo = tbl[31:0];
        cfg_hash_hi = tbl[63:32];
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] tbl;
        logic        exp_acc;
        bit          early;

        // R9: reset state.
        repeat (3) @(negedge clk);
        check(dec_valid == 1'b0, "R9 valid at reset", dec_valid, 0);
        check(dec_accept == 1'b0, "R9 accept at reset", dec_accept, 0);
        rst_n = 1'b1;

        // R8: bytes without a first-byte marker after reset are ignored.
        early = 1'b0;
        for (int i = 0; i < 8; i++) begin
            drive_byte(8'hFF, 1'b0);
            @(negedge clk);
            if (dec_valid) early = 1'b1;
        end
        go_idle();
        check(!early && !dec_valid, "R8 unmarked bytes ignored", early, 0);

        // Vector table: R2 to R7.
        for (int v = 0; v < NVEC; v++) begin
            case (VECS[v].tsel)
                2'd0: tbl = '0;
                2'd1: tbl = '1;
                2'd2: tbl = 64'd1 << model_hash(VECS[v].addr);
                default: tbl = 64'd1 << (model_hash(VECS[v].addr) ^ 6'd1);
            endcase
            set_cfg(VECS[v].en, tbl);
            exp_acc = model_accept(VECS[v].addr, VECS[v].en, tbl);
            send_addr(VECS[v].addr);
            check(dec_valid == 1'b1, "R7 strobe after sixth byte", dec_valid, 1);
            check(dec_accept == exp_acc, "R2/R3/R4/R5/R6 accept vector", dec_accept, exp_acc);
            check(dec_hash == model_hash(VECS[v].addr), "R1 hash vector", dec_hash,
                  model_hash(VECS[v].addr));
            @(negedge clk);
            check(dec_valid == 1'b0, "R7 strobe one cycle", dec_valid, 0);
        end

        // R1: hand-worked hash values in both halves of the table.
        set_cfg(3'b001, '0);
        send_addr(48'h01_00_5E_00_00_01);
        check(dec_hash == 6'd14, "R1 hash 14", dec_hash, 14);
        send_addr(48'h01_00_5E_00_00_21);
        check(dec_hash == 6'd46, "R1 hash 46", dec_hash, 46);
        // R2: high-word bit 14 (index 46) set, so the frame is accepted.
        set_cfg(3'b001, 64'd1 << 46);
        send_addr(48'h01_00_5E_00_00_21);
        check(dec_accept == 1'b1, "R2 high word bit 14", dec_accept, 1);

        // R7: idle cycles between bytes delay the strobe only.
        set_cfg(3'b000, '0);
        early = 1'b0;
        for (int i = 0; i < 6; i++) begin
            drive_byte(STATION[47-8*i -: 8], i == 0);
            go_idle();
            if (i < 5 && dec_valid) early = 1'b1;
            @(negedge clk);
            if (dec_valid) early = 1'b1;
        end
        check(!early, "R7 no early strobe with gaps", early, 0);
        // The final go_idle above sampled the strobe; the trailing idle saw it drop.
        // Repeat the gapped send, this time sampling right after the sixth byte.
        for (int i = 0; i < 6; i++) begin
            drive_byte(STATION[47-8*i -: 8], i == 0);
            if (i < 5) go_idle();
        end
        go_idle();
        check(dec_valid && dec_accept, "R7 R6 gapped station accepted",
              {dec_valid, dec_accept}, 2'b11);

        // R8: bytes beyond the sixth produce no second strobe.
        for (int i = 0; i < 6; i++)
            drive_byte(STATION[47-8*i -: 8], i == 0);
        drive_byte(8'h00, 1'b0);
        check(dec_valid == 1'b1, "R8 strobe with extra bytes", dec_valid, 1);
        early = 1'b0;
        for (int i = 0; i < 4; i++) begin
            drive_byte(8'h00, 1'b0);
            if (dec_valid) early = 1'b1;
        end
        go_idle();
        if (dec_valid) early = 1'b1;
        check(!early, "R8 extra bytes ignored", early, 0);

        // R8: a first-byte marker mid-address restarts the count.
        set_cfg(3'b001, '0);
        drive_byte(8'hFF, 1'b1);
        drive_byte(8'hFF, 1'b0);
        drive_byte(8'hFF, 1'b0);
        early = 1'b0;
        for (int i = 0; i < 6; i++) begin
            drive_byte(STATION[47-8*i -: 8], i == 0);
            if (dec_valid) early = 1'b1;
        end
        go_idle();
        check(!early && dec_valid && dec_accept, "R8 restart decides on new address",
              {early, dec_valid, dec_accept}, 3'b011);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule